// File: doc/BRIEF.md
# Identity- and Privilege-Checked Thermal Limit Register Slave

This block is a small register file for a power-management peripheral. Its lower registers hold thermal-shutdown limits, and its upper registers hold ordinary settings. Every request carries a mandatory request-side attribute field. That field gives the identity of the master that issued the request and its privilege level. The slave checks each access against its own rules at its own port. It does not trust the address alone, and it does not trust any check made upstream.

Each request is accepted in the cycle it is presented. Exactly one response follows on the next cycle. The response carries read data and a response-side attribute field that states whether the access was granted or why it was refused. A refused write leaves storage untouched. Reads are open to every requester. Writes to a limit register are allowed only for a supervisor whose identity is on a parameterised allow-list. The ordinary registers accept writes from anyone.

Top module: `thermal_cfg_slave`

## Requirements
- R1: After reset, `rsp_valid` is 0, every limit register (addresses below `NUM_LIMIT`, default 4) reads as `LIMIT_RST` (default 16'h0055), and every other register reads as zero.
- R2: Each request with `req_valid` high gives `rsp_valid` high in the next cycle. A cycle with `req_valid` low gives `rsp_valid` low in the next cycle. Back-to-back requests each get their own response.
- R3: A read from any identity at any privilege is granted. It returns `rsp_info` = 2'b00 and the register content in `rsp_rdata`.
- R4: The request field `req_info` holds the identity in bits [2:0] and privilege in bit [3], where 1 means supervisor. A supervisor write to a limit register from an identity whose bit is set in `ALLOW_MASK` (default: identities 0 and 2) is granted with code 2'b00 and stores the data.
- R5: A write to a limit register with privilege bit 0 is refused with code 2'b01, and the register keeps its value.
- R6: A supervisor write to a limit register from an identity that is not allow-listed is refused with code 2'b10, and the register keeps its value.
- R7: When a limit write fails both tests, the privilege refusal takes priority and the code is 2'b01.
- R8: Registers at `NUM_LIMIT` and above accept writes from any identity and privilege, with code 2'b00.
- R9: Every write response carries zero in `rsp_rdata`. The code 2'b11 is never returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register index |
| req_wdata | input | DATA_W | Write data |
| req_info | input | 4 | Requester attributes: [2:0] identity, [3] supervisor |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_rdata | output | DATA_W | Read data, zero for writes and refusals |
| rsp_info | output | 2 | Outcome: 00 granted, 01 privilege refused, 10 identity refused |

## Verification
The bench targets the edges of the limit range. Addresses NUM_LIMIT-1 and NUM_LIMIT sit on opposite sides of the protection boundary, so an off-by-one compare would either lock an ordinary register or expose a limit register. It sends a user write from an allow-listed identity and a supervisor write from an identity off the list. A design that tested only one of the two attributes would let one of these writes corrupt a limit, and the readback after each refusal would show the change. A request that fails both tests checks the code priority. Back-to-back traffic checks that a design with a response pipeline off by a cycle would drop or repeat a response.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int ID_W   = 3;
  localparam int INFO_W = ID_W + 1;

  typedef struct packed {
    logic            sup;
    logic [ID_W-1:0] id;
  } req_attr_t;

  typedef enum logic [1:0] {
    RSP_OK        = 2'b00,
    RSP_DENY_PRIV = 2'b01,
    RSP_DENY_ID   = 2'b10,
    RSP_RSVD      = 2'b11
  } rsp_code_e;
endpackage

// File: rtl/tcs_access_check.sv
module tcs_access_check
  import tcs_pkg::*;
#(
  parameter int                ADDR_W     = 3,
  parameter int                NUM_LIMIT  = 4,
  parameter logic [2**ID_W-1:0] ALLOW_MASK = 8'b0000_0101
) (
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  req_attr_t         attr,
  output logic              grant,
  output rsp_code_e         code
);
  localparam logic [ADDR_W:0] LIM = NUM_LIMIT[ADDR_W:0];

  logic guarded;
  logic id_listed;

  always_comb begin
    guarded   = is_write && ({1'b0, addr} < LIM);
    id_listed = ALLOW_MASK[attr.id];
    if (!guarded)       code = RSP_OK;
    else if (!attr.sup) code = RSP_DENY_PRIV;
    else if (!id_listed) code = RSP_DENY_ID;
    else                code = RSP_OK;
    grant = (code == RSP_OK);
  end
endmodule

// File: rtl/tcs_reg_bank.sv
module tcs_reg_bank #(
  parameter int              DATA_W    = 16,
  parameter int              ADDR_W    = 3,
  parameter int              NUM_LIMIT = 4,
  parameter logic [DATA_W-1:0] LIMIT_RST = 16'h0055
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NUM_REGS = 2**ADDR_W;

  logic [NUM_REGS-1:0][DATA_W-1:0] q, q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt[wr_addr] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++)
        q[i] <= (i < NUM_LIMIT) ? LIMIT_RST : '0;
    end else if (wr_en) begin
      q <= q_nxt;
    end
  end

  assign rd_data = q[rd_addr];

  // R5 / R6: storage moves only on an enabled write
  p_hold_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/thermal_cfg_slave.sv
module thermal_cfg_slave
  import tcs_pkg::*;
#(
  parameter int                 DATA_W     = 16,
  parameter int                 ADDR_W     = 3,
  parameter int                 NUM_LIMIT  = 4,
  parameter logic [2**ID_W-1:0] ALLOW_MASK = 8'b0000_0101,
  parameter logic [DATA_W-1:0]  LIMIT_RST  = 16'h0055
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [INFO_W-1:0] req_info,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_info
);
  localparam logic [ADDR_W:0] LIM = NUM_LIMIT[ADDR_W:0];

  req_attr_t         attr;
  logic              grant;
  rsp_code_e         code;
  logic              wr_en;
  logic [DATA_W-1:0] rd_data;

  logic              rsp_valid_nxt;
  logic [DATA_W-1:0] rsp_rdata_nxt;
  rsp_code_e         rsp_code_q, rsp_code_nxt;
  logic              rsp_en;

  assign attr  = req_attr_t'(req_info);
  assign wr_en = req_valid && req_write && grant;

  tcs_access_check #(
    .ADDR_W(ADDR_W), .NUM_LIMIT(NUM_LIMIT), .ALLOW_MASK(ALLOW_MASK)
  ) u_check (
    .is_write(req_write), .addr(req_addr), .attr(attr),
    .grant(grant), .code(code)
  );

  tcs_reg_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_LIMIT(NUM_LIMIT), .LIMIT_RST(LIMIT_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(req_addr),
    .wr_data(req_wdata), .rd_addr(req_addr), .rd_data(rd_data)
  );

  always_comb begin
    rsp_valid_nxt = req_valid;
    rsp_code_nxt  = req_valid ? code : RSP_OK;
    rsp_rdata_nxt = (req_valid && !req_write && grant) ? rd_data : '0;
    rsp_en        = req_valid || rsp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_code_q <= RSP_OK;
    end else begin
      rsp_valid <= rsp_valid_nxt;
      if (rsp_en) begin
        rsp_rdata  <= rsp_rdata_nxt;
        rsp_code_q <= rsp_code_nxt;
      end
    end
  end

  assign rsp_info = rsp_code_q;

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_read_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (rsp_info == RSP_OK));
  p_user_limit_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_info[INFO_W-1] && ({1'b0, req_addr} < LIM))
      |=> (rsp_info == RSP_DENY_PRIV));
  p_write_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == '0));
  p_no_reserved_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_info != RSP_RSVD));
endmodule

// File: tb/thermal_cfg_slave_test.sv
module thermal_cfg_slave_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [2:0]  req_addr;
  logic [15:0] req_wdata;
  logic [3:0]  req_info;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [1:0]  rsp_info;

  int checks;
  int failures;
  logic [15:0] model [8];

  thermal_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_info(req_info),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_info(rsp_info)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request, response sampled at the following negedge
  task automatic xfer(input logic wr, input logic [2:0] a, input logic [15:0] d,
                      input logic sup, input logic [2:0] id,
                      output logic v, output logic [1:0] code, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_info = {sup, id};
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    v = rsp_valid; code = rsp_info; rd = rsp_rdata;
  endtask

  task automatic readback(input string tag, input logic [2:0] a);
    logic v; logic [1:0] c; logic [15:0] rd;
    xfer(1'b0, a, 16'h0, 1'b0, 3'd7, v, c, rd);
    check({tag, " readback data"}, rd, model[a]);
    check({tag, " readback code"}, c, 2'b00);
  endtask

  task automatic t_reset;
    check("R1 rsp_valid after reset", rsp_valid, 1'b0);
    for (int i = 0; i < 8; i++) readback("R1", 3'(i));
  endtask

  task automatic t_read_any;
    logic v; logic [1:0] c; logic [15:0] rd;
    xfer(1'b0, 3'd2, 16'hFFFF, 1'b0, 3'd5, v, c, rd);
    check("R3 user read valid", v, 1'b1);
    check("R3 user read code", c, 2'b00);
    check("R3 user read data", rd, model[2]);
  endtask

  task automatic t_sup_write;
    logic v; logic [1:0] c; logic [15:0] rd;
    xfer(1'b1, 3'd1, 16'h1234, 1'b1, 3'd0, v, c, rd);
    check("R4 id0 write code", c, 2'b00);
    check("R9 write data zero", rd, 16'h0);
    model[1] = 16'h1234;
    readback("R4 id0", 3'd1);
    xfer(1'b1, 3'd3, 16'hBEEF, 1'b1, 3'd2, v, c, rd);
    check("R4 id2 top limit code", c, 2'b00);
    model[3] = 16'hBEEF;
    readback("R4 id2", 3'd3);
  endtask

  task automatic t_user_write;
    logic v; logic [1:0] c; logic [15:0] rd;
    xfer(1'b1, 3'd1, 16'hDEAD, 1'b0, 3'd0, v, c, rd);
    check("R5 user write code", c, 2'b01);
    check("R9 denied write data", rd, 16'h0);
    readback("R5 unchanged", 3'd1);
  endtask

  task automatic t_bad_id;
    logic v; logic [1:0] c; logic [15:0] rd;
    xfer(1'b1, 3'd3, 16'h0BAD, 1'b1, 3'd3, v, c, rd);
    check("R6 id3 write code", c, 2'b10);
    readback("R6 unchanged", 3'd3);
    xfer(1'b1, 3'd0, 16'h0BAD, 1'b1, 3'd1, v, c, rd);
    check("R6 id1 write code", c, 2'b10);
    readback("R6 unchanged", 3'd0);
  endtask

  task automatic t_both_bad;
    logic v; logic [1:0] c; logic [15:0] rd;
    xfer(1'b1, 3'd0, 16'h7777, 1'b0, 3'd5, v, c, rd);
    check("R7 priority code", c, 2'b01);
    readback("R7 unchanged", 3'd0);
  endtask

  task automatic t_open;
    logic v; logic [1:0] c; logic [15:0] rd;
    xfer(1'b1, 3'd4, 16'hA5A5, 1'b0, 3'd6, v, c, rd);
    check("R8 lowest open reg code", c, 2'b00);
    model[4] = 16'hA5A5;
    readback("R8", 3'd4);
    xfer(1'b1, 3'd7, 16'h5A5A, 1'b0, 3'd3, v, c, rd);
    check("R8 top open reg code", c, 2'b00);
    model[7] = 16'h5A5A;
    readback("R8", 3'd7);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd5; req_wdata = 16'hC0DE; req_info = 4'b0100;
    @(negedge clk);
    check("R2 first response valid", rsp_valid, 1'b1);
    check("R2 first response code", rsp_info, 2'b00);
    model[5] = 16'hC0DE;
    req_write = 1'b0;
    @(negedge clk);
    check("R2 second response valid", rsp_valid, 1'b1);
    check("R2 second response data", rsp_rdata, model[5]);
    req_valid = 1'b0;
    @(negedge clk);
    check("R2 idle no response", rsp_valid, 1'b0);
    @(negedge clk);
    check("R2 still idle", rsp_valid, 1'b0);
  endtask

  initial begin
    checks = 0; failures = 0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_info = '0;
    for (int i = 0; i < 8; i++) model[i] = (i < 4) ? 16'h0055 : 16'h0000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_any();
    t_sup_write();
    t_user_write();
    t_bad_id();
    t_both_bad();
    t_open();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule